// File: doc/BRIEF.md
# Operand-Fetch and Write-Back Handshake Controller

This block coordinates one operation through a compute unit that sits between an issue stage, a register-file scoreboard and a pipelined ALU. A one-cycle issue pulse starts the operation and latches its operation code. On the next cycle the unit reports busy. Each source operand then gets its own read request. The operand's value is captured when the scoreboard returns that operand's read grant.

Once every operand has been granted, the unit offers the operands to the ALU through a valid/ready handshake. It then waits for the ALU result, also through valid/ready, and keeps the result in a holding register. Next it raises a write request. A low shadow input holds that request back. On the write grant the held value goes to the result port and the unit returns to idle.

A kill input aborts the operation at any point while busy. It clears the control state and discards the held result, so a killed operation never writes back.

Top module: `cuhs_top`

## Requirements
- R1: After synchronous reset the following are all zero: busyOut, every rdReqOut bit, wrReqOut, aluValidOut, aluResReadyOut and resultOut.
- R2: An issue pulse sampled while idle makes busyOut high on the following cycle. busyOut stays high until the operation completes or is killed.
- R3: rdReqOut is zero whenever busyOut is low. On the cycle after issue, all read-request bits are high, with bit i belonging to operand i.
- R4: When rdReqOut[i] and rdGntIn[i] are both high at a clock edge, two things happen on the next cycle: srcIn bits [i*16 +: 16] sampled at that edge appear on aluOperandsOut bits [i*16 +: 16], and rdReqOut[i] is low.
- R5: aluValidOut rises on the cycle after the last outstanding read grant. It stays high until aluReadyIn is sampled high, and is low on the following cycle.
- R6: After the ALU accepts the operands, aluResReadyOut is high until aluResValidIn is sampled high. wrReqOut stays low until that result has been captured.
- R7: During the write phase, wrReqOut is high exactly when shadowN is high. It never rises while shadowN is low.
- R8: When wrReqOut and wrGntIn are both high at an edge, the following cycle shows the captured ALU result on resultOut, with wrReqOut low and busyOut low.
- R9: killIn sampled high while busy makes the next cycle idle: busyOut is low, rdReqOut is zero, wrReqOut and aluValidOut are low, and resultOut is unchanged. killIn while idle has no effect.
- R10: aluOpOut carries the opIn value sampled with issue, and it stays unchanged for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueIn | input | 1 | One-cycle issue pulse |
| opIn | input | 4 | Operation code presented with issue |
| busyOut | output | 1 | Operation in flight |
| rdReqOut | output | 3 | Per-operand read request |
| rdGntIn | input | 3 | Per-operand read grant |
| srcIn | input | 48 | Operand values, operand i at bits [i*16 +: 16] |
| killIn | input | 1 | Abort the current operation |
| shadowN | input | 1 | Active-low shadow, low holds back write request |
| wrReqOut | output | 1 | Write-back request |
| wrGntIn | input | 1 | Write-back grant |
| resultOut | output | 16 | Last written-back result |
| aluValidOut | output | 1 | Operands valid towards the ALU |
| aluReadyIn | input | 1 | ALU accepts operands |
| aluOpOut | output | 4 | Latched operation code towards the ALU |
| aluOperandsOut | output | 48 | Latched operands towards the ALU |
| aluResValidIn | input | 1 | ALU result valid |
| aluResIn | input | 16 | ALU result value |
| aluResReadyOut | output | 1 | Unit ready to take the ALU result |

## Verification
Assertions check the following on every cycle: busy follows issue, no read request appears while idle, each read request drops after its grant, the operand valid is held until ready, the write request never rises under shadow, busy drops after a write grant, a kill returns the unit to idle, and the operation code stays stable. Other behaviours are value-level and can only be shown by the bench's scenarios. These are: the correct operand captured under random grant orders and changing source data, the exact result value driven after the write grant, and the result port left untouched by a kill in each phase and by a kill while idle.

// File: rtl/cuhs_pkg.sv
package cuhs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_SEND  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WRITE = 3'd4
  } cuState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;
    logic capRes;
    logic drvRes;
    logic dropRes;
  } cuStrobe_t;

endpackage

// File: rtl/cuhs_ctrl.sv
module cuhs_ctrl
  import cuhs_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issueIn,
  input  logic               killIn,
  input  logic [NUM_SRC-1:0] rdGntIn,
  input  logic               shadowN,
  input  logic               wrGntIn,
  input  logic               aluReadyIn,
  input  logic               aluResValidIn,
  output logic               busyOut,
  output logic [NUM_SRC-1:0] rdReqOut,
  output logic               wrReqOut,
  output logic               aluValidOut,
  output logic               aluResReadyOut,
  output cuStrobe_t          strobe,
  output logic [NUM_SRC-1:0] srcLatch
);

  localparam logic [NUM_SRC-1:0] ALL_SRC = {NUM_SRC{1'b1}};

  cuState_e           state, nextState;
  logic [NUM_SRC-1:0] pending, nextPending;
  logic [NUM_SRC-1:0] grantHit;
  logic               killHit;

  always_comb begin
    busyOut        = (state != ST_IDLE);
    killHit        = killIn && busyOut;
    rdReqOut       = (state == ST_READ) ? pending : '0;
    grantHit       = rdReqOut & rdGntIn;
    aluValidOut    = (state == ST_SEND);
    aluResReadyOut = (state == ST_WAIT);
    wrReqOut       = (state == ST_WRITE) && shadowN;

    srcLatch       = grantHit;
    strobe.latchOp = (state == ST_IDLE) && issueIn;
    strobe.capRes  = (state == ST_WAIT) && aluResValidIn && !killHit;
    strobe.drvRes  = wrReqOut && wrGntIn && !killHit;
    strobe.dropRes = killHit;
  end

  always_comb begin
    nextState   = state;
    nextPending = pending;
    unique case (state)
      ST_IDLE: if (issueIn) begin
        nextState   = ST_READ;
        nextPending = ALL_SRC;
      end
      ST_READ: begin
        nextPending = pending & ~grantHit;
        if (nextPending == '0) nextState = ST_SEND;
      end
      ST_SEND:  if (aluReadyIn) nextState = ST_WAIT;
      ST_WAIT:  if (aluResValidIn) nextState = ST_WRITE;
      ST_WRITE: if (wrReqOut && wrGntIn) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
    if (killHit) begin
      nextState   = ST_IDLE;
      nextPending = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pending <= '0;
    end else begin
      state   <= nextState;
      pending <= nextPending;
    end
  end

  // R2: busy follows an accepted issue
  assert_busy_after_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (issueIn && !busyOut) |=> busyOut);

  // R3: no read request while idle
  assert_no_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busyOut |-> (rdReqOut == '0));

  // R4: each read request drops after its grant
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rdChk
    assert_read_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (rdReqOut[i] && rdGntIn[i]) |=> !rdReqOut[i]);
  end

  // R5: valid towards the ALU is held until ready
  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (aluValidOut && !aluReadyIn && !killIn) |=> aluValidOut);

  // R7: write request never rises under shadow
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wrReqOut |=> (shadowN || !wrReqOut));

  // R8: write grant ends the operation
  assert_write_done_R8: assert property (@(posedge clk) disable iff (rst)
    (wrReqOut && wrGntIn && !killIn) |=> (!busyOut && !wrReqOut));

  // R9: kill returns to idle
  assert_kill_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (killIn && busyOut) |=> (!busyOut && rdReqOut == '0 && !wrReqOut && !aluValidOut));

endmodule

// File: rtl/cuhs_dpath.sv
module cuhs_dpath
  import cuhs_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  cuStrobe_t                 strobe,
  input  logic [NUM_SRC-1:0]        srcLatch,
  input  logic [OP_W-1:0]           opIn,
  input  logic [NUM_SRC*DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0]         aluResIn,
  output logic [OP_W-1:0]           aluOpOut,
  output logic [NUM_SRC*DATA_W-1:0] aluOperandsOut,
  output logic [DATA_W-1:0]         resultOut
);

  logic [OP_W-1:0]   opReg;
  logic [DATA_W-1:0] heldRes;
  logic [DATA_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (rst) opReg <= '0;
    else if (strobe.latchOp) opReg <= opIn;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [DATA_W-1:0] held;
    always_ff @(posedge clk) begin
      if (rst) held <= '0;
      else if (srcLatch[i]) held <= srcIn[i*DATA_W +: DATA_W];
    end
    assign aluOperandsOut[i*DATA_W +: DATA_W] = held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldRes   <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.dropRes)     heldRes <= '0;
      else if (strobe.capRes) heldRes <= aluResIn;
      if (strobe.drvRes) resultReg <= heldRes;
    end
  end

  assign aluOpOut  = opReg;
  assign resultOut = resultReg;

  // R8: the driven result is the held one
  assert_result_drive_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.drvRes |=> (resultOut == $past(heldRes)));

  // R9: a kill leaves the result port alone
  assert_kill_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.dropRes && !strobe.drvRes) |=> $stable(resultOut));

endmodule

// File: rtl/cuhs_top.sv
module cuhs_top
  import cuhs_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issueIn,
  input  logic [OP_W-1:0]           opIn,
  output logic                      busyOut,
  output logic [NUM_SRC-1:0]        rdReqOut,
  input  logic [NUM_SRC-1:0]        rdGntIn,
  input  logic [NUM_SRC*DATA_W-1:0] srcIn,
  input  logic                      killIn,
  input  logic                      shadowN,
  output logic                      wrReqOut,
  input  logic                      wrGntIn,
  output logic [DATA_W-1:0]         resultOut,
  output logic                      aluValidOut,
  input  logic                      aluReadyIn,
  output logic [OP_W-1:0]           aluOpOut,
  output logic [NUM_SRC*DATA_W-1:0] aluOperandsOut,
  input  logic                      aluResValidIn,
  input  logic [DATA_W-1:0]         aluResIn,
  output logic                      aluResReadyOut
);

  cuStrobe_t          strobe;
  logic [NUM_SRC-1:0] srcLatch;

  cuhs_ctrl #(.NUM_SRC(NUM_SRC)) ctrl (
    .clk(clk), .rst(rst), .issueIn(issueIn), .killIn(killIn),
    .rdGntIn(rdGntIn), .shadowN(shadowN), .wrGntIn(wrGntIn),
    .aluReadyIn(aluReadyIn), .aluResValidIn(aluResValidIn),
    .busyOut(busyOut), .rdReqOut(rdReqOut), .wrReqOut(wrReqOut),
    .aluValidOut(aluValidOut), .aluResReadyOut(aluResReadyOut),
    .strobe(strobe), .srcLatch(srcLatch)
  );

  cuhs_dpath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .OP_W(OP_W)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .srcLatch(srcLatch),
    .opIn(opIn), .srcIn(srcIn), .aluResIn(aluResIn),
    .aluOpOut(aluOpOut), .aluOperandsOut(aluOperandsOut),
    .resultOut(resultOut)
  );

  // R10: operation code stable while busy
  assert_op_stable_R10: assert property (@(posedge clk) disable iff (rst)
    busyOut |=> (!busyOut || $stable(aluOpOut)));

endmodule

// File: tb/cuhs_top_test.sv
`timescale 1ns/100ps
module cuhs_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueIn = 1'b0;
  logic [3:0]  opIn = '0;
  logic        busyOut;
  logic [2:0]  rdReqOut;
  logic [2:0]  rdGntIn = '0;
  logic [47:0] srcIn = '0;
  logic        killIn = 1'b0;
  logic        shadowN = 1'b1;
  logic        wrReqOut;
  logic        wrGntIn = 1'b0;
  logic [15:0] resultOut;
  logic        aluValidOut;
  logic        aluReadyIn = 1'b0;
  logic [3:0]  aluOpOut;
  logic [47:0] aluOperandsOut;
  logic        aluResValidIn = 1'b0;
  logic [15:0] aluResIn = '0;
  logic        aluResReadyOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  logic [15:0] lastRes = '0;
  logic [15:0] expSrc [3];
  logic [3:0]  expOp;

  always #2 clk = ~clk;

  cuhs_top uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #0.5;
  endtask

  function automatic logic [15:0] aluModel(input logic [3:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input logic [15:0] c);
    case (op[1:0])
      2'd0: return a + b + c;
      2'd1: return a ^ b ^ c;
      2'd2: return (a & b) | c;
      default: return a - b;
    endcase
  endfunction

  task automatic checkIdle(input string req);
    check(!busyOut, req, 64'(busyOut), 0);
    check(rdReqOut == 0, req, 64'(rdReqOut), 0);
    check(!wrReqOut && !aluValidOut, req, {wrReqOut, aluValidOut}, 0);
    check(resultOut == lastRes, req, 64'(resultOut), 64'(lastRes));
  endtask

  task automatic doKill();
    killIn = 1'b1;
    tick();
    killIn = 1'b0;
    checkIdle("R9 kill");
  endtask

  // killPhase: 0 none, 1 read, 2 send, 3 wait, 4 write
  task automatic runOp(input int killPhase, input bit useShadow);
    logic [2:0] pending;
    logic [2:0] mask;
    logic [15:0] r;
    expOp = 4'($urandom);
    opIn = expOp;
    srcIn = {$urandom, $urandom};
    issueIn = 1'b1;
    tick();
    issueIn = 1'b0;
    opIn = ~expOp;
    check(busyOut, "R2 busy", 64'(busyOut), 1);
    check(rdReqOut == 3'b111, "R3 all requests", 64'(rdReqOut), 64'h7);
    check(aluOpOut == expOp, "R10 op", 64'(aluOpOut), 64'(expOp));
    if (killPhase == 1) begin
      rdGntIn = 3'b001;
      tick();
      rdGntIn = '0;
      doKill();
      return;
    end
    pending = 3'b111;
    while (pending != 0) begin
      mask = 3'($urandom) & pending;
      srcIn = {$urandom, $urandom};
      rdGntIn = mask;
      for (int i = 0; i < 3; i++) if (mask[i]) expSrc[i] = srcIn[i*16 +: 16];
      tick();
      rdGntIn = '0;
      pending = pending & ~mask;
      check(rdReqOut == pending, "R4 request drop", 64'(rdReqOut), 64'(pending));
      for (int i = 0; i < 3; i++)
        if (mask[i])
          check(aluOperandsOut[i*16 +: 16] == expSrc[i], "R4 operand",
                64'(aluOperandsOut[i*16 +: 16]), 64'(expSrc[i]));
      check(aluValidOut == (pending == 0), "R5 valid", 64'(aluValidOut), 64'(pending == 0));
    end
    if (killPhase == 2) begin doKill(); return; end
    repeat ($urandom % 3) begin
      tick();
      check(aluValidOut, "R5 hold", 64'(aluValidOut), 1);
    end
    aluReadyIn = 1'b1;
    tick();
    aluReadyIn = 1'b0;
    check(!aluValidOut && aluResReadyOut, "R6 wait", {aluValidOut, aluResReadyOut}, 64'h1);
    check(!wrReqOut, "R6 no write", 64'(wrReqOut), 0);
    if (killPhase == 3) begin doKill(); return; end
    repeat ($urandom % 3) begin
      tick();
      check(aluResReadyOut && !wrReqOut, "R6 waiting", {aluResReadyOut, wrReqOut}, 64'h2);
    end
    r = aluModel(expOp, expSrc[0], expSrc[1], expSrc[2]);
    aluResIn = r;
    aluResValidIn = 1'b1;
    shadowN = !useShadow;
    tick();
    aluResValidIn = 1'b0;
    aluResIn = ~r;
    if (useShadow) begin
      repeat (1 + $urandom % 3) begin
        check(!wrReqOut, "R7 shadowed", 64'(wrReqOut), 0);
        tick();
      end
      check(!wrReqOut, "R7 shadowed", 64'(wrReqOut), 0);
      shadowN = 1'b1;
      #0.5;
    end
    check(wrReqOut, "R7 request", 64'(wrReqOut), 1);
    check(aluOpOut == expOp, "R10 op held", 64'(aluOpOut), 64'(expOp));
    if (killPhase == 4) begin doKill(); return; end
    wrGntIn = 1'b1;
    tick();
    wrGntIn = 1'b0;
    check(resultOut == r, "R8 result", 64'(resultOut), 64'(r));
    check(!busyOut && !wrReqOut, "R8 idle", {busyOut, wrReqOut}, 0);
    lastRes = r;
  endtask

  initial begin
    void'($urandom(32'h1234));
    tick(); tick();
    rst = 1'b0;
    check(!busyOut && rdReqOut == 0 && !wrReqOut && !aluValidOut && !aluResReadyOut,
          "R1 reset", {busyOut, rdReqOut, wrReqOut, aluValidOut, aluResReadyOut}, 0);
    check(resultOut == 0, "R1 result", 64'(resultOut), 0);
    runOp(0, 0);
    runOp(0, 1);
    // kill while idle
    killIn = 1'b1;
    tick();
    killIn = 1'b0;
    checkIdle("R9 idle kill");
    for (int k = 1; k <= 4; k++) begin
      runOp(k, k[0]);
      runOp(0, 0);
    end
    for (int n = 0; n < 40; n++) runOp(($urandom % 4 == 0) ? 1 + $urandom % 4 : 0, $urandom % 2 == 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    lastRes = '0;
    check(resultOut == 0 && !busyOut, "R1 mid reset", {busyOut, resultOut}, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule